// File: doc/BRIEF.md
# Bidirectional 16-to-32 Bit Link Packer

This block joins a 16-bit point-to-point parallel link, shared by both directions, to a 32-bit word interface inside the chip. Only one end of the link drives the shared data lines at a time. That end is the owner. It moves one halfword per link clock, and the link write-enable marks each valid halfword. The non-owner gathers the halfwords it receives, two at a time, into 32-bit words and queues them in a receive FIFO. The owner takes 32-bit words from a transmit FIFO and sends each one as two halfwords.

Two auxiliary lines carry a request/acknowledge handshake that passes ownership between the ends. A non-owner with queued transmit data raises request. The owner finishes any word it has half sent. It then answers with a one-cycle acknowledge and releases the bus. A single direction output sets the data, link clock and write-enable pins together. The request and acknowledge lines each have their own direction output. In this block the link clock is the block clock, with a target of 100 MHz.

Top module: `hw_link_packer`

## Requirements
- R1: After reset, ownership equals the parameter OWN_AT_RESET. Both FIFOs are empty, and `link_we_o`, `ack_o` and `req_o` are low.
- R2: `link_oe` and `ack_oe` are high exactly while the block owns the bus, and `req_oe` is high exactly while it does not. The block never asserts `link_we_o` unless it owns the bus.
- R3: A halfword is taken from `link_dat_i` only on a clock edge where `link_we_i` is high and the block does not own the bus. All other values on the data lines have no effect on the receive FIFO.
- R4: Of two consecutive received halfwords, the first becomes bits [15:0] of the word and the second becomes bits [31:16]. The word enters the receive FIFO on the edge that takes the second halfword, and leaves in arrival order through `rx_data`/`rx_valid`, popped by `rx_ready`.
- R5: `rx_full` is high while the receive FIFO holds DEPTH words, and `rdy_o` is its inverse. A word completed while the FIFO is full is discarded.
- R6: While it owns the bus, the block sends each queued word as its bits [15:0] and then its bits [31:16], one halfword per cycle with `link_we_o` high.
- R7: While `rdy_i` is low the block sends nothing. When `rdy_i` returns high it resumes with the same halfword.
- R8: While the block does not own the bus, `req_o` is high exactly when the transmit FIFO holds a word.
- R9: An owner that sees `req_i` high with no word half sent raises `ack_o` for that cycle and sends nothing. It releases the bus on the next edge. If the low half of a word has been sent, the high half goes out first.
- R10: A non-owner that sees `ack_i` high on a clock edge owns the bus from the next cycle.
- R11: A received low halfword that is waiting for its partner is kept across changes of ownership. It is paired with the next halfword the block receives.
- R12: `tx_ready` is high exactly while the transmit FIFO holds fewer than DEPTH words, and a word is queued when `tx_valid` and `tx_ready` are both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block and link clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| link_dat_i | input | 16 | Halfword seen on the shared data lines |
| link_dat_o | output | 16 | Halfword driven onto the data lines |
| link_oe | output | 1 | Drive enable for data, link clock and write-enable pins |
| link_we_i | input | 1 | Write-enable seen on the link |
| link_we_o | output | 1 | Write-enable driven onto the link |
| req_i | input | 1 | Request line seen from the peer |
| req_o | output | 1 | Request line value driven to the peer |
| req_oe | output | 1 | Drive enable of the request line |
| ack_i | input | 1 | Acknowledge line seen from the peer |
| ack_o | output | 1 | Acknowledge line value driven to the peer |
| ack_oe | output | 1 | Drive enable of the acknowledge line |
| rdy_i | input | 1 | Peer can accept halfwords |
| rdy_o | output | 1 | This block can accept a further word |
| tx_data | input | 32 | Word to queue for transmission |
| tx_valid | input | 1 | `tx_data` is valid |
| tx_ready | output | 1 | Transmit FIFO has room |
| rx_data | output | 32 | Oldest received word |
| rx_valid | output | 1 | Receive FIFO is not empty |
| rx_ready | input | 1 | Pop the oldest received word |
| rx_full | output | 1 | Receive FIFO holds DEPTH words |

## Verification
The bench builds the block with DEPTH = 4 and OWN_AT_RESET = 0. The small depth lets a few received words fill the receive FIFO, so a discarded fifth word and a refused fifth transmit word are both reached. Starting as non-owner means the run covers the request, acknowledge and takeover path and then a handover back under a half-sent word. It also keeps a received low halfword waiting across two ownership changes.

// File: rtl/hw_link_packer.sv
module hw_link_packer #(
  parameter int DEPTH        = 8,
  parameter bit OWN_AT_RESET = 1'b0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [15:0] link_dat_i,
  output logic [15:0] link_dat_o,
  output logic        link_oe,
  input  logic        link_we_i,
  output logic        link_we_o,
  input  logic        req_i,
  output logic        req_o,
  output logic        req_oe,
  input  logic        ack_i,
  output logic        ack_o,
  output logic        ack_oe,
  input  logic        rdy_i,
  output logic        rdy_o,
  input  logic [31:0] tx_data,
  input  logic        tx_valid,
  output logic        tx_ready,
  output logic [31:0] rx_data,
  output logic        rx_valid,
  input  logic        rx_ready,
  output logic        rx_full
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
  localparam logic [CW-1:0] FULL = CW'(DEPTH);

  logic          owner, tx_ph, rx_mid;
  logic [15:0]   rx_hold;
  logic [31:0]   tx_mem [DEPTH];
  logic [31:0]   rx_mem [DEPTH];
  logic [AW-1:0] tx_wr, tx_rd, rx_wr, rx_rd;
  logic [CW-1:0] tx_cnt, rx_cnt;
  logic [31:0]   tx_head;
  logic          grant, send, tx_push, tx_pop, rx_cap, rx_push, rx_pop;

  assign tx_head    = tx_mem[tx_rd];
  assign grant      = owner & req_i & ~tx_ph;
  assign send       = owner & (tx_cnt != '0) & rdy_i & ~grant;
  assign tx_ready   = tx_cnt != FULL;
  assign tx_push    = tx_valid & tx_ready;
  assign tx_pop     = send & tx_ph;

  assign rx_full    = rx_cnt == FULL;
  assign rx_valid   = rx_cnt != '0;
  assign rx_data    = rx_mem[rx_rd];
  assign rx_cap     = ~owner & link_we_i;
  assign rx_push    = rx_cap & rx_mid & ~rx_full;
  assign rx_pop     = rx_valid & rx_ready;

  assign link_oe    = owner;
  assign ack_oe     = owner;
  assign req_oe     = ~owner;
  assign link_we_o  = send;
  assign link_dat_o = tx_ph ? tx_head[31:16] : tx_head[15:0];
  assign ack_o      = grant;
  assign req_o      = ~owner & (tx_cnt != '0);
  assign rdy_o      = ~rx_full;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      owner <= OWN_AT_RESET;
    end else if (grant) begin
      owner <= 1'b0;
    end else if (!owner && ack_i) begin
      owner <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_ph  <= 1'b0;
      tx_wr  <= '0;
      tx_rd  <= '0;
      tx_cnt <= '0;
    end else begin
      if (send) tx_ph <= ~tx_ph;
      if (tx_push) tx_wr <= (tx_wr == LAST) ? '0 : tx_wr + 1'b1;
      if (tx_pop)  tx_rd <= (tx_rd == LAST) ? '0 : tx_rd + 1'b1;
      tx_cnt <= tx_cnt + CW'(tx_push) - CW'(tx_pop);
    end
  end

  always_ff @(posedge clk) begin
    if (tx_push) tx_mem[tx_wr] <= tx_data;
    if (rx_push) rx_mem[rx_wr] <= {link_dat_i, rx_hold};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_mid  <= 1'b0;
      rx_hold <= '0;
      rx_wr   <= '0;
      rx_rd   <= '0;
      rx_cnt  <= '0;
    end else begin
      if (rx_cap) begin
        rx_mid <= ~rx_mid;
        if (!rx_mid) rx_hold <= link_dat_i;
      end
      if (rx_push) rx_wr <= (rx_wr == LAST) ? '0 : rx_wr + 1'b1;
      if (rx_pop)  rx_rd <= (rx_rd == LAST) ? '0 : rx_rd + 1'b1;
      rx_cnt <= rx_cnt + CW'(rx_push) - CW'(rx_pop);
    end
  end
endmodule

// File: rtl/link_packer_chk.sv
module link_packer_chk (
  input logic clk,
  input logic rst_n,
  input logic link_oe,
  input logic link_we_o,
  input logic req_o,
  input logic ack_i,
  input logic ack_o,
  input logic rdy_i,
  input logic rx_full,
  input logic rx_ready
);
  assert_we_owner_R2: assert property (@(posedge clk) disable iff (!rst_n)
    link_we_o |-> link_oe);
  assert_ack_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ack_o |-> (link_oe && !link_we_o));
  assert_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ack_o |=> !link_oe);
  assert_take_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!link_oe && ack_i) |=> link_oe);
  assert_stall_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !rdy_i |-> !link_we_o);
  assert_req_R8: assert property (@(posedge clk) disable iff (!rst_n)
    req_o |-> !link_oe);
  assert_no_overflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_full && !rx_ready) |=> rx_full);
endmodule

bind hw_link_packer link_packer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .link_oe(link_oe), .link_we_o(link_we_o),
  .req_o(req_o), .ack_i(ack_i), .ack_o(ack_o), .rdy_i(rdy_i),
  .rx_full(rx_full), .rx_ready(rx_ready)
);

// File: tb/hw_link_packer_bench.sv
module hw_link_packer_bench;
  localparam int DEPTH = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [15:0] link_dat_i = '0, link_dat_o;
  logic link_oe, link_we_i = 1'b0, link_we_o;
  logic req_i = 1'b0, req_o, req_oe, ack_i = 1'b0, ack_o, ack_oe;
  logic rdy_i = 1'b1, rdy_o;
  logic [31:0] tx_data = '0, rx_data;
  logic tx_valid = 1'b0, tx_ready, rx_valid, rx_ready = 1'b0, rx_full;

  int checks = 0, errors = 0;
  string tag = "";

  logic [31:0] txq[$];
  logic [31:0] rxq[$];
  logic m_owner = 1'b0, m_txph = 1'b0, m_rxmid = 1'b0;
  logic [15:0] m_hold = '0;

  hw_link_packer #(.DEPTH(DEPTH), .OWN_AT_RESET(1'b0)) u_hw_link_packer (
    .clk(clk), .rst_n(rst_n), .link_dat_i(link_dat_i), .link_dat_o(link_dat_o),
    .link_oe(link_oe), .link_we_i(link_we_i), .link_we_o(link_we_o),
    .req_i(req_i), .req_o(req_o), .req_oe(req_oe), .ack_i(ack_i), .ack_o(ack_o),
    .ack_oe(ack_oe), .rdy_i(rdy_i), .rdy_o(rdy_o), .tx_data(tx_data),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .rx_data(rx_data),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_full(rx_full)
  );

  always #10 clk = ~clk;

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic cyc();
    logic e_grant, e_send, e_full, e_pop;
    logic [15:0] e_dat;
    #1;
    e_grant = m_owner && req_i && !m_txph;
    e_send  = m_owner && txq.size() > 0 && rdy_i && !e_grant;
    e_full  = rxq.size() == DEPTH;
    e_dat   = 16'h0;
    if (txq.size() > 0) e_dat = m_txph ? txq[0][31:16] : txq[0][15:0];
    chk("R2", "link_oe", 32'(link_oe), 32'(m_owner));
    chk("R2", "ack_oe", 32'(ack_oe), 32'(m_owner));
    chk("R2", "req_oe", 32'(req_oe), 32'(!m_owner));
    chk("R9", "ack_o", 32'(ack_o), 32'(e_grant));
    chk("R8", "req_o", 32'(req_o), 32'(!m_owner && txq.size() > 0));
    chk({"R6 ", tag}, "link_we_o", 32'(link_we_o), 32'(e_send));
    if (e_send) chk({"R6 ", tag}, "link_dat_o", 32'(link_dat_o), 32'(e_dat));
    chk("R5", "rx_full", 32'(rx_full), 32'(e_full));
    chk("R5", "rdy_o", 32'(rdy_o), 32'(!e_full));
    chk("R12", "tx_ready", 32'(tx_ready), 32'(txq.size() < DEPTH));
    chk({"R4 ", tag}, "rx_valid", 32'(rx_valid), 32'(rxq.size() > 0));
    if (rxq.size() > 0) chk({"R4 ", tag}, "rx_data", rx_data, rxq[0]);
    // next state of the reference
    e_pop = rxq.size() > 0 && rx_ready;
    if (e_pop) void'(rxq.pop_front());
    if (!m_owner && link_we_i) begin
      if (!m_rxmid) begin
        m_hold = link_dat_i;
        m_rxmid = 1'b1;
      end else begin
        m_rxmid = 1'b0;
        if (!e_full) rxq.push_back({link_dat_i, m_hold});
      end
    end
    if (tx_valid && txq.size() < DEPTH) begin
      if (e_send && m_txph) begin
        void'(txq.pop_front());
        txq.push_back(tx_data);
      end else txq.push_back(tx_data);
    end else if (e_send && m_txph) void'(txq.pop_front());
    if (e_send) m_txph = !m_txph;
    if (e_grant) m_owner = 1'b0;
    else if (!m_owner && ack_i) m_owner = 1'b1;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic half(logic [15:0] d);
    link_we_i = 1'b1;
    link_dat_i = d;
    cyc();
    link_we_i = 1'b0;
    link_dat_i = 16'hdead;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) cyc();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL R1 watchdog expired actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    tag = "R1";
    chk("R1", "owner after reset", 32'(link_oe), 32'd0);
    chk("R1", "rx_valid after reset", 32'(rx_valid), 32'd0);
    chk("R1", "tx_ready after reset", 32'(tx_ready), 32'd1);
    chk("R1", "link_we_o/ack_o/req_o after reset", 32'({link_we_o, ack_o, req_o}), 32'd0);

    tag = "R3";
    half(16'h1111); idle(2); half(16'h2222);
    half(16'h3333); half(16'h4444);
    idle(1);

    tag = "R5";
    half(16'h5555); half(16'h6666);
    half(16'h7777); half(16'h8888);
    half(16'h9999); half(16'haaaa);
    idle(1);
    rx_ready = 1'b1; idle(5); rx_ready = 1'b0;

    tag = "R11";
    half(16'h0a0a);

    tag = "R12";
    tx_valid = 1'b1;
    for (int i = 0; i < 5; i++) begin
      tx_data = 32'hc0de_0000 + 32'(i) * 32'h0001_0101;
      cyc();
    end
    tx_valid = 1'b0;

    tag = "R10";
    ack_i = 1'b1; cyc(); ack_i = 1'b0;

    tag = "R7";
    link_we_i = 1'b1;
    for (int i = 0; i < 8; i++) begin
      rdy_i = (i % 3) != 0;
      link_dat_i = 16'hbad0 + 16'(i);
      cyc();
    end
    link_we_i = 1'b0;
    rdy_i = 1'b1;

    tag = "R9";
    req_i = 1'b1; idle(3); req_i = 1'b0;

    tag = "R11";
    half(16'hb0b0);
    rx_ready = 1'b1; idle(2); rx_ready = 1'b0;

    tag = "R6";
    ack_i = 1'b1; cyc(); ack_i = 1'b0;
    idle(4);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule